// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter with Coherent Byte Read

This block is a free-running 16-bit up-counter that sits on an 8-bit register bus. Each count step is enabled either by a tap of a binary prescaler that divides the bus clock by 1, 2, 4, 8, 16, 32 or 64, or by rising edges of an external clock pin after that pin has been synchronized. A single control register selects the source. The same register holds a halt bit and a self-clearing clear bit. The clear bit resets both the counter and the prescaler.

Software reads the count one byte at a time. Reading the upper byte captures the lower byte into a holding buffer, so a read of the upper byte followed by a read of the lower byte returns one consistent 16-bit value while the counter keeps running. When the counter rolls over, the block raises a one-cycle wrap strobe.

Register offsets on `bus_addr`: 0 is the control register, 1 is the count upper byte, 2 is the count lower byte, and 3 reads as zero. Control register fields: bits [2:0] are the source select, bit 4 is the clear bit, bit 5 is the halt bit, and all other bits read 0.

Top module: `pscl_timer`

## Requirements
- R1: After system reset the count is 0x0000, the select field is 000, the halt bit is 0, the control register reads 0x00 and `cnt_wrap` is 0.
- R2: With select code k in 0..6, the count advances once every 2^k clock cycles. The prescaler is zero right after a clear, so N cycles after the clear write the count equals N >> k.
- R3: With select code 7, each rising edge on `ext_clk` advances the count by exactly one, after a two-flop synchronizer and an edge detector.
- R4: Writing 1 to control bit 4 zeroes the count and the prescaler at that write's clock edge, and counting then restarts from 0x0000. Select and halt take the values written in the same write.
- R5: Control bit 4 is write-only and always reads 0.
- R6: A control write with both bit 5 (halt) and bit 4 (clear) set leaves the count held at 0x0000 until halt is cleared.
- R7: While halt is 1, the counter and the prescaler both keep their values. After halt is cleared, counting resumes from the held count and the held prescaler phase.
- R8: A read of offset 1 returns the live upper byte and copies the live lower byte into a buffer. Later reads of offset 2 return the buffered byte until offset 2 has been read once.
- R9: A read of offset 2 with no pending buffered byte returns the live lower byte, and that read releases the buffer.
- R10: Writes to offsets 1 and 2 leave the count unchanged.
- R11: When a count step moves the count from 0xFFFF to 0x0000, `cnt_wrap` is high for exactly the one cycle in which the count reads 0x0000.
- R12: The control register reads back the select field in bits [2:0] and halt in bit 5, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | 2 | Register offset (0 control, 1 count upper, 2 count lower) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` (combinational) |
| ext_clk | input | 1 | External count clock, asynchronous to `clk` |
| cnt_wrap | output | 1 | One-cycle strobe on a 0xFFFF to 0x0000 rollover |

## Verification
The assertions take the bus to carry at most one access per cycle: `bus_rd` and `bus_wr` are never high together, and the lower-byte release is assumed to come only from a genuine offset-2 read. They also take `ext_clk` to stay at each level for at least two bus clocks, so that every rising edge produces one synchronized pulse and no edge is lost. The stimulus issues single-cycle reads and writes that never overlap. It holds the external clock high for three cycles and low for three cycles per period, and it changes every input one nanosecond after the active edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // register offsets on the byte bus
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_CNT_HI = 2'd1,
      REG_CNT_LO = 2'd2,
      REG_NONE   = 2'd3
   } reg_sel_e;

   // control register field positions
   localparam int unsigned CTRL_SEL_LSB  = 0;
   localparam int unsigned CTRL_CLR_BIT  = 4;
   localparam int unsigned CTRL_HALT_BIT = 5;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned STAGES = 7,
   parameter int unsigned SEL_W  = $clog2(STAGES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             hold,
   input  logic [SEL_W-1:0] sel,
   output logic             div_tick
);

   localparam int unsigned PSC_W  = STAGES - 1;
   localparam int unsigned N_TAPS = 1 << SEL_W;

   logic [PSC_W-1:0]  psc_q;
   logic [N_TAPS-1:0] taps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       psc_q <= '0;
      else if (clear)   psc_q <= '0;
      else if (!hold)   psc_q <= psc_q + PSC_W'(1);
   end

   // tap k fires once every 2**k cycles; codes beyond the last stage give no tick
   for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
      if (k == 0) begin : g_every
         assign taps[k] = 1'b1;
      end else if (k < STAGES) begin : g_div
         assign taps[k] = &psc_q[k-1:0];
      end else begin : g_none
         assign taps[k] = 1'b0;
      end
   end

   assign div_tick = taps[sel];

   // R7
   psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clear) |=> $stable(psc_q));

   // R4
   psc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (psc_q == '0));

endmodule

// File: rtl/tmr_extsync.sv
module tmr_extsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_pin,
   output logic edge_pulse
);

   // STAGES synchronizer flops plus one history flop for edge detection
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], ext_pin};
   end

   assign edge_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];

   // R3
   ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse |=> !edge_pulse);

endmodule

// File: rtl/tmr_count16.sv
module tmr_count16 #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   logic [CNT_W-1:0] cnt_q;
   logic             wrap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wrap_q <= 1'b0;
      end else if (clear) begin
         cnt_q  <= '0;
         wrap_q <= 1'b0;
      end else begin
         wrap_q <= step & (&cnt_q);
         if (step) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt  = cnt_q;
   assign wrap = wrap_q;

   // R11
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> (cnt == '0));

   // R11
   wrap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> !wrap);

   // R4
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // R10
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> $stable(cnt));

endmodule

// File: rtl/tmr_readbuf.sv
module tmr_readbuf #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              release_lo,
   input  logic [BYTE_W-1:0] live_lo,
   output logic [BYTE_W-1:0] lo_view
);

   logic [BYTE_W-1:0] held_q;
   logic              valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= '0;
         valid_q <= 1'b0;
      end else if (capture) begin
         held_q  <= live_lo;
         valid_q <= 1'b1;
      end else if (release_lo) begin
         valid_q <= 1'b0;
      end
   end

   assign lo_view = valid_q ? held_q : live_lo;

   // R8
   buf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !capture) |=> $stable(held_q));

   // R8
   buf_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (valid_q && held_q == $past(live_lo)));

   // R9
   buf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (release_lo && !capture) |=> (lo_view == live_lo));

endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
   import tmr_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned DIV_STAGES  = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              ext_clk,
   output logic              cnt_wrap
);

   localparam int unsigned CNT_W = 2 * BYTE_W;
   localparam int unsigned SEL_W = $clog2(DIV_STAGES + 1);
   localparam logic [SEL_W-1:0] EXT_CODE = {SEL_W{1'b1}};

   // elaboration-time parameter checks
   if (BYTE_W < CTRL_HALT_BIT + 1) begin : g_bad_byte
      $error("BYTE_W too narrow for the control fields");
   end
   if (SEL_W > CTRL_CLR_BIT) begin : g_bad_sel
      $error("select field overlaps the clear bit");
   end
   if ((DIV_STAGES + 1) != (1 << SEL_W)) begin : g_bad_div
      $error("DIV_STAGES + 1 must be a power of two so the top code selects the pin");
   end
   if (DIV_STAGES < 2) begin : g_bad_min
      $error("DIV_STAGES must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SEL_W-1:0]  sel_q;
   logic              halt_q;
   logic              wr_ctrl, clr_pulse;
   logic              div_tick, ext_pulse, step;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] lo_view;
   logic [BYTE_W-1:0] ctrl_view;

   assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
   assign clr_pulse = wr_ctrl && bus_wdata[CTRL_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         halt_q <= 1'b0;
      end else if (wr_ctrl) begin
         sel_q  <= bus_wdata[CTRL_SEL_LSB +: SEL_W];
         halt_q <= bus_wdata[CTRL_HALT_BIT];
      end
   end

   tmr_prescaler #(.STAGES(DIV_STAGES), .SEL_W(SEL_W)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clr_pulse),
      .hold     (halt_q),
      .sel      (sel_q),
      .div_tick (div_tick)
   );

   tmr_extsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_pin    (ext_clk),
      .edge_pulse (ext_pulse)
   );

   assign step = ~halt_q & ((sel_q == EXT_CODE) ? ext_pulse : div_tick);

   tmr_count16 #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clr_pulse),
      .step  (step),
      .cnt   (cnt),
      .wrap  (cnt_wrap)
   );

   tmr_readbuf #(.BYTE_W(BYTE_W)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (bus_rd && (bus_addr == REG_CNT_HI)),
      .release_lo (bus_rd && (bus_addr == REG_CNT_LO)),
      .live_lo    (cnt[BYTE_W-1:0]),
      .lo_view    (lo_view)
   );

   always_comb begin
      ctrl_view = '0;
      ctrl_view[CTRL_SEL_LSB +: SEL_W] = sel_q;
      ctrl_view[CTRL_HALT_BIT]         = halt_q;
   end

   always_comb begin
      case (bus_addr)
         REG_CTRL:   bus_rdata = ctrl_view;
         REG_CNT_HI: bus_rdata = cnt[CNT_W-1:BYTE_W];
         REG_CNT_LO: bus_rdata = lo_view;
         default:    bus_rdata = '0;
      endcase
   end

   // R7
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !clr_pulse) |=> $stable(cnt));

   // R6
   park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[CTRL_HALT_BIT] && bus_wdata[CTRL_CLR_BIT])
      |=> (cnt == '0 && halt_q));

   // R5
   clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> !bus_rdata[CTRL_CLR_BIT] || (bus_addr != REG_CTRL));

   // R10
   cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != REG_CTRL && !step) |=> $stable(cnt));

endmodule

// File: tb/sim_pscl_timer.sv
module sim_pscl_timer;
   localparam int PER = 8;   // 125 MHz

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       ext = 1'b0;
   logic       wrap;

   always #(PER/2) clk = ~clk;

   pscl_timer u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata), .ext_clk(ext), .cnt_wrap(wrap)
   );

   int    checks = 0, errors = 0;
   bit    done = 1'b0;
   string phase = "R1";

   // behavioural reference model
   int m_cnt, m_psc, m_sel, m_halt, m_buf, m_bufv, m_ovf;
   bit m_s1, m_s2, m_s3;

   always @(posedge clk) begin : model
      int old_cnt;
      bit tick, clr, wctl;
      if (!rst_n) begin
         m_cnt = 0; m_psc = 0; m_sel = 0; m_halt = 0;
         m_buf = 0; m_bufv = 0; m_ovf = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
      end else begin
         old_cnt = m_cnt;
         wctl = wr && addr == 2'd0;
         clr  = wctl && wdata[4];
         if (m_sel == 7) tick = m_s2 && !m_s3;
         else            tick = (m_psc % (1 << m_sel)) == ((1 << m_sel) - 1);
         if (clr) begin
            m_cnt = 0; m_psc = 0; m_ovf = 0;
         end else if (!m_halt) begin
            m_psc = (m_psc + 1) % 64;
            m_ovf = (tick && m_cnt == 65535) ? 1 : 0;
            if (tick) m_cnt = (m_cnt + 1) % 65536;
         end else begin
            m_ovf = 0;
         end
         if (wctl) begin
            m_sel  = wdata[2:0];
            m_halt = wdata[5];
         end
         if (rd && addr == 2'd1) begin
            m_buf = old_cnt % 256; m_bufv = 1;
         end else if (rd && addr == 2'd2) begin
            m_bufv = 0;
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext;
      end
   end

   function automatic int model_rd(input logic [1:0] a);
      case (a)
         2'd0:    return (m_halt << 5) | m_sel;
         2'd1:    return m_cnt / 256;
         2'd2:    return m_bufv ? m_buf : (m_cnt % 256);
         default: return 0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // compare against the model on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(rdata == 8'(model_rd(addr)), phase, rdata, model_rd(addr));
         check(wrap == m_ovf[0], {phase, " wrap"}, wrap, m_ovf);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
      addr = a; wdata = v; wr = 1'b1;
      cyc(1);
      wr = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output int v);
      addr = a; #1; v = rdata;
   endtask

   task automatic rd_reg(input logic [1:0] a, output int v);
      addr = a; rd = 1'b1; #1; v = rdata;
      cyc(1);
      rd = 1'b0;
   endtask

   task automatic peek_cnt(output int v);
      int h, l;
      peek(2'd1, h); peek(2'd2, l);
      v = h * 256 + l;
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired in phase %s actual 0 expected 1", phase);
         finish_run();
      end
   end

   initial begin : stim
      int v, a, b;
      cyc(3);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      peek(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 8'h00);
      peek_cnt(v);   check(v == 0, "R1 count", v, 0);
      check(wrap == 1'b0, "R1 wrap", wrap, 0);
      cyc(1);

      // R2 prescaler divisions
      phase = "R2";
      for (int k = 0; k < 7; k += 2) begin
         int kk;
         kk = (k == 6) ? 6 : k;
         wr_reg(2'd0, 8'h10 | 8'(kk));
         cyc(128);
         peek_cnt(v); check(v == (128 >> kk), "R2 divide", v, 128 >> kk);
      end

      // R4 clear, R5/R12 readback
      phase = "R4";
      wr_reg(2'd0, 8'h13);
      peek_cnt(v); check(v == 0, "R4 cleared", v, 0);
      peek(2'd0, v); check(v == 8'h03, "R5 R12 ctrl readback", v, 8'h03);
      cyc(16);
      peek_cnt(v); check(v == 2, "R4 restart", v, 2);

      // R7 prescaler phase held across halt
      phase = "R7";
      wr_reg(2'd0, 8'h13);
      cyc(5);
      wr_reg(2'd0, 8'h23);
      cyc(20);
      peek_cnt(v); check(v == 0, "R7 held", v, 0);
      wr_reg(2'd0, 8'h03);
      cyc(1);
      peek_cnt(v); check(v == 0, "R7 phase kept a", v, 0);
      cyc(1);
      peek_cnt(v); check(v == 1, "R7 phase kept b", v, 1);

      // R7 counter hold and resume
      wr_reg(2'd0, 8'h00);
      cyc(10);
      wr_reg(2'd0, 8'h20);
      peek_cnt(a);
      peek(2'd0, v); check(v == 8'h20, "R12 halt bit", v, 8'h20);
      cyc(20);
      peek_cnt(v); check(v == a, "R7 hold", v, a);
      wr_reg(2'd0, 8'h00);
      cyc(10);
      peek_cnt(v); check(v == a + 10, "R7 resume", v, a + 10);

      // R6 halt and clear together
      phase = "R6";
      wr_reg(2'd0, 8'h30);
      cyc(30);
      peek_cnt(v); check(v == 0, "R6 parked", v, 0);

      // R10 writes to count offsets
      phase = "R10";
      wr_reg(2'd1, 8'hFF);
      wr_reg(2'd2, 8'hFF);
      cyc(2);
      peek_cnt(v); check(v == 0, "R10 ignored", v, 0);

      // R8 / R9 byte read latch
      phase = "R8";
      wr_reg(2'd0, 8'h10);
      cyc(300);
      rd_reg(2'd1, v); check(v == 8'h01, "R8 upper", v, 8'h01);
      cyc(10);
      peek(2'd2, v); check(v == 8'h2C, "R8 frozen", v, 8'h2C);
      rd_reg(2'd2, v); check(v == 8'h2C, "R8 buffered", v, 8'h2C);
      phase = "R9";
      peek(2'd2, v); check(v == 8'h38, "R9 live after release", v, 8'h38);
      peek(2'd2, a); cyc(5); peek(2'd2, b);
      check(b == ((a + 5) % 256), "R9 live", b, (a + 5) % 256);

      // R11 wrap
      phase = "R11";
      wr_reg(2'd0, 8'h10);
      cyc(65535);
      peek_cnt(v); check(v == 16'hFFFF, "R11 top", v, 16'hFFFF);
      check(wrap == 1'b0, "R11 no strobe yet", wrap, 0);
      cyc(1);
      peek_cnt(v); check(v == 0, "R11 rolled", v, 0);
      check(wrap == 1'b1, "R11 strobe", wrap, 1);
      cyc(1);
      check(wrap == 1'b0, "R11 strobe ends", wrap, 0);

      // R3 external clock
      phase = "R3";
      wr_reg(2'd0, 8'h17);
      for (int p = 0; p < 5; p++) begin
         ext = 1'b1; cyc(3);
         ext = 1'b0; cyc(3);
      end
      cyc(4);
      peek_cnt(v); check(v == 5, "R3 edges", v, 5);

      cyc(2);
      finish_run();
   end

endmodule